// File: doc/BRIEF.md
# Receive FIFO Interrupt and Flag Controller

This block sits on the receive side of a UART-style serial port. Characters that the line receiver has already assembled arrive on a byte stream and go into a 16-entry receive queue. Each character carries its framing and parity error tags, or marks a break instead of data. The block compares the queue's fill level with a trigger count that software selects. It keeps sticky status flags and raises three interrupt requests:

- a threshold (data-full) request,
- an error request,
- a break request.

A single enable bit gates all three requests.

Software reaches the block through a small register port with four addresses: control, status, data pop and level. The threshold flag has a guarded clear. Software must first read it as 1 and then write 0. That write only takes effect once software has popped enough characters that the fill level is below the trigger. The other status flags use the same read-1/write-0 sequence, without the level condition.

The byte stream uses valid/ready. `in_ready` follows the receiver enable. While it is low, nothing is consumed, which stands for the receiver not detecting a start bit. While it is high, every offered character is consumed in the cycle it is valid. A character consumed while the queue holds 16 entries is dropped and reported as an overrun. The block never stalls the sender for a full queue.

Top module: `rxq_irq_ctrl`

## Requirements
- R1: After the synchronous active-high reset, the control register, all status flags and the fill level are 0, and all three interrupt outputs are low.
- R2: The control register (address 0) holds:
  - bit 0: interrupt enable;
  - bit 1: receiver enable;
  - bits 3:2: trigger select.
  Bits 7:4 read as 0 and ignore writes.
- R3: The trigger select picks the trigger level: 0 gives 1, 1 gives 4, 2 gives 8 and 3 gives 14 entries. The threshold flag is set on the clock edge after a cycle in which the fill level is at or above the trigger.
- R4: The threshold flag is cleared by a status read that returns it as 1, followed later by a status write with bit 0 at 0 while the fill level is below the trigger. A write without that prior read, or a write while the level is at or above the trigger, leaves the flag at 1.
- R5: The interrupt outputs follow the flags and the interrupt enable:
  - `irq_rxi` = enable AND threshold flag;
  - `irq_eri` = enable AND error flag;
  - `irq_bri` = enable AND break flag.
  Clearing the enable withdraws all three requests and leaves the flags unchanged.
- R6: `in_ready` equals the receiver enable. With the receiver disabled, no character enters the queue. Clearing the receiver enable leaves the queue and all status flags unchanged.
- R7: A read of address 2 returns the oldest stored character and removes it, so characters leave in arrival order. A read of address 2 on an empty queue returns 0 and changes nothing. Address 3 returns:
  - bits 4:0: the fill level;
  - bit 5: the head entry's framing error;
  - bit 6: the head entry's parity error.
- R8: A character tagged with a framing or parity error is stored with its tags. When it is stored, the block sets the matching framing or parity flag and the error flag.
- R9: A data character consumed while the queue holds 16 entries is discarded and sets the overrun flag and the error flag.
- R10: A character marked as a break is not stored and sets the break flag.
- R11: The error, break, framing, parity and overrun flags are cleared by a status read that returns them as 1, followed by a status write of 0 in their bit. Writing 1, or writing without the prior read, has no effect. A flag never drops without a status write.
- R12: The status register (address 1) holds:
  - bit 0: threshold;
  - bit 1: error;
  - bit 2: break;
  - bit 3: framing;
  - bit 4: parity;
  - bit 5: overrun.
  Bits 7:6 read as 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| in_valid | input | 1 | A received character is offered |
| in_ready | output | 1 | Character consumed this cycle (equals receiver enable) |
| in_data | input | 8 | Received character |
| in_fer | input | 1 | Framing error tag of the character |
| in_per | input | 1 | Parity error tag of the character |
| in_brk | input | 1 | The offered item is a break condition, not data |
| reg_wr | input | 1 | Register write strobe |
| reg_rd | input | 1 | Register read strobe (pops at address 2, arms clears at address 1) |
| reg_addr | input | 2 | Register address |
| reg_wdata | input | 8 | Register write data |
| reg_rdata | output | 8 | Register read data, combinational from address |
| irq_rxi | output | 1 | Receive threshold interrupt request |
| irq_eri | output | 1 | Receive error interrupt request |
| irq_bri | output | 1 | Break interrupt request |

## Verification
The assertions check four rules on every cycle:
- the fill level never passes the queue depth;
- a pop on an empty queue or a drop on a full one leaves the level as it was;
- the level can only grow while the receiver is enabled;
- no flag falls without a status write, and the threshold flag sets and stays set while the level is at the trigger.

Only the bench's scenarios can show the rest:
- the read-then-write order of the guarded clear, including its refusal while the level is still at the trigger;
- the arrival order of popped characters;
- the storage of error tags and the head-entry view;
- that gating by the interrupt enable and disabling the receiver leave the flags untouched.

// File: rtl/rxq_pkg.sv
package rxq_pkg;

  typedef struct packed {
    logic       per;
    logic       fer;
    logic [7:0] data;
  } rxq_entry_t;

  typedef enum logic [1:0] {
    ADR_CTRL  = 2'd0,
    ADR_STAT  = 2'd1,
    ADR_DATA  = 2'd2,
    ADR_LEVEL = 2'd3
  } rxq_addr_e;

  localparam int NFLAG    = 6;
  localparam int F_THRESH = 0;
  localparam int F_ERR    = 1;
  localparam int F_BRK    = 2;
  localparam int F_FER    = 3;
  localparam int F_PER    = 4;
  localparam int F_OVR    = 5;

  // trigger level from the 2-bit select, scaled to the queue depth
  function automatic int unsigned trig_level(input logic [1:0] sel, input int unsigned depth);
    case (sel)
      2'd0:    return 1;
      2'd1:    return depth / 4;
      2'd2:    return depth / 2;
      default: return depth - 2;
    endcase
  endfunction

endpackage

// File: rtl/rxq_store.sv
module rxq_store
  import rxq_pkg::*;
#(
  parameter  int DEPTH = 16,
  localparam int AW    = $clog2(DEPTH),
  localparam int CW    = $clog2(DEPTH + 1)
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          push,
  input  logic          pop,
  input  rxq_entry_t    wr_entry,
  output rxq_entry_t    head,
  output logic [CW-1:0] count,
  output logic          full,
  output logic          dropped
);

  rxq_entry_t      mem [DEPTH];
  logic [AW-1:0]   wr_ptr, rd_ptr;
  logic            empty, do_push, do_pop;

  function automatic logic [AW-1:0] ptr_next(input logic [AW-1:0] p);
    return (p == AW'(DEPTH - 1)) ? '0 : p + 1'b1;
  endfunction

  assign full    = (count == CW'(DEPTH));
  assign empty   = (count == '0);
  assign do_push = push && !full;
  assign do_pop  = pop && !empty;
  assign dropped = push && full;
  assign head    = empty ? '0 : mem[rd_ptr];

  always_ff @(posedge clk) begin
    if (do_push) mem[wr_ptr] <= wr_entry;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      wr_ptr <= '0;
      rd_ptr <= '0;
      count  <= '0;
    end else begin
      if (do_push) wr_ptr <= ptr_next(wr_ptr);
      if (do_pop)  rd_ptr <= ptr_next(rd_ptr);
      case ({do_push, do_pop})
        2'b10:   count <= count + 1'b1;
        2'b01:   count <= count - 1'b1;
        default: count <= count;
      endcase
    end
  end

  AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (rst)
    count <= CW'(DEPTH)); // R9

  AST_DROP_KEEPS_LEVEL: assert property (@(posedge clk) disable iff (rst)
    (push && full && !pop) |=> (count == CW'(DEPTH))); // R9

  AST_EMPTY_POP_NOOP: assert property (@(posedge clk) disable iff (rst)
    (empty && pop && !push) |=> (count == '0)); // R7

endmodule

// File: rtl/rxq_flags.sv
module rxq_flags #(
  parameter int NF = 6
) (
  input  logic          clk,
  input  logic          rst,
  input  logic [NF-1:0] set_ev,
  input  logic [NF-1:0] clr_ok,
  input  logic          stat_rd,
  input  logic          stat_wr,
  input  logic [NF-1:0] wdata,
  output logic [NF-1:0] flags
);

  logic [NF-1:0] armed;

  for (genvar i = 0; i < NF; i++) begin : g_flag
    always_ff @(posedge clk) begin
      if (rst) begin
        flags[i] <= 1'b0;
        armed[i] <= 1'b0;
      end else begin
        if (set_ev[i])
          flags[i] <= 1'b1;
        else if (stat_wr && armed[i] && !wdata[i] && clr_ok[i])
          flags[i] <= 1'b0;

        if (stat_wr)
          armed[i] <= 1'b0;
        else if (stat_rd && flags[i])
          armed[i] <= 1'b1;
      end
    end
  end

  AST_NO_SILENT_CLEAR: assert property (@(posedge clk) disable iff (rst)
    !stat_wr |=> ((flags & $past(flags)) == $past(flags))); // R11

endmodule

// File: rtl/rxq_irq_ctrl.sv
module rxq_irq_ctrl
  import rxq_pkg::*;
#(
  parameter  int DEPTH = 16,
  localparam int CW    = $clog2(DEPTH + 1)
) (
  input  logic       clk,
  input  logic       rst,
  input  logic       in_valid,
  output logic       in_ready,
  input  logic [7:0] in_data,
  input  logic       in_fer,
  input  logic       in_per,
  input  logic       in_brk,
  input  logic       reg_wr,
  input  logic       reg_rd,
  input  logic [1:0] reg_addr,
  input  logic [7:0] reg_wdata,
  output logic [7:0] reg_rdata,
  output logic       irq_rxi,
  output logic       irq_eri,
  output logic       irq_bri
);

  logic             rie_q, rx_en_q;
  logic [1:0]       trig_sel_q;
  logic [CW-1:0]    count, trig_lvl;
  logic             full, dropped, accept, push_req, stored, lvl_ge;
  logic             wr_ctrl, stat_rd, stat_wr, pop;
  rxq_entry_t       head, wr_entry;
  logic [NFLAG-1:0] set_ev, clr_ok, flags;
  logic             unused_wbits;

  assign unused_wbits = ^reg_wdata[7:6];

  // register decode
  assign wr_ctrl = reg_wr && (reg_addr == ADR_CTRL);
  assign stat_wr = reg_wr && (reg_addr == ADR_STAT);
  assign stat_rd = reg_rd && (reg_addr == ADR_STAT);
  assign pop     = reg_rd && (reg_addr == ADR_DATA);

  always_ff @(posedge clk) begin
    if (rst) begin
      rie_q      <= 1'b0;
      rx_en_q    <= 1'b0;
      trig_sel_q <= 2'd0;
    end else if (wr_ctrl) begin
      rie_q      <= reg_wdata[0];
      rx_en_q    <= reg_wdata[1];
      trig_sel_q <= reg_wdata[3:2];
    end
  end

  // input stream: consumed whenever the receiver is on
  assign in_ready = rx_en_q;
  assign accept   = in_valid && rx_en_q;
  assign push_req = accept && !in_brk;
  assign stored   = push_req && !full;
  assign wr_entry = '{per: in_per, fer: in_fer, data: in_data};

  rxq_store #(.DEPTH(DEPTH)) u_store (
    .clk      (clk),
    .rst      (rst),
    .push     (push_req),
    .pop      (pop),
    .wr_entry (wr_entry),
    .head     (head),
    .count    (count),
    .full     (full),
    .dropped  (dropped)
  );

  assign trig_lvl = CW'(trig_level(trig_sel_q, DEPTH));
  assign lvl_ge   = (count >= trig_lvl);

  always_comb begin
    set_ev           = '0;
    set_ev[F_THRESH] = lvl_ge;
    set_ev[F_ERR]    = dropped || (stored && (in_fer || in_per));
    set_ev[F_BRK]    = accept && in_brk;
    set_ev[F_FER]    = stored && in_fer;
    set_ev[F_PER]    = stored && in_per;
    set_ev[F_OVR]    = dropped;
    clr_ok           = '1;
    clr_ok[F_THRESH] = !lvl_ge;
  end

  rxq_flags #(.NF(NFLAG)) u_flags (
    .clk     (clk),
    .rst     (rst),
    .set_ev  (set_ev),
    .clr_ok  (clr_ok),
    .stat_rd (stat_rd),
    .stat_wr (stat_wr),
    .wdata   (reg_wdata[NFLAG-1:0]),
    .flags   (flags)
  );

  assign irq_rxi = rie_q && flags[F_THRESH];
  assign irq_eri = rie_q && flags[F_ERR];
  assign irq_bri = rie_q && flags[F_BRK];

  always_comb begin
    case (reg_addr)
      ADR_CTRL:  reg_rdata = {4'b0000, trig_sel_q, rx_en_q, rie_q};
      ADR_STAT:  reg_rdata = {2'b00, flags};
      ADR_DATA:  reg_rdata = head.data;
      default:   reg_rdata = {1'b0, head.per, head.fer, 5'(count)};
    endcase
  end

  AST_THRESH_SETS: assert property (@(posedge clk) disable iff (rst)
    lvl_ge |=> flags[F_THRESH]); // R3

  AST_THRESH_HELD: assert property (@(posedge clk) disable iff (rst)
    (flags[F_THRESH] && lvl_ge) |=> flags[F_THRESH]); // R4

  AST_RX_OFF_NO_FILL: assert property (@(posedge clk) disable iff (rst)
    !in_ready |=> (count <= $past(count))); // R6

endmodule

// File: tb/tb_rxq_irq_ctrl.sv
module tb_rxq_irq_ctrl;
  localparam int CLK_PERIOD = 10;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       in_valid = 1'b0, in_fer = 1'b0, in_per = 1'b0, in_brk = 1'b0;
  logic [7:0] in_data = 8'h00;
  logic       reg_wr = 1'b0, reg_rd = 1'b0;
  logic [1:0] reg_addr = 2'd0;
  logic [7:0] reg_wdata = 8'h00;
  logic       in_ready, irq_rxi, irq_eri, irq_bri;
  logic [7:0] reg_rdata;

  int n_chk = 0;
  int n_err = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  rxq_irq_ctrl dut (
    .clk(clk), .rst(rst), .in_valid(in_valid), .in_ready(in_ready),
    .in_data(in_data), .in_fer(in_fer), .in_per(in_per), .in_brk(in_brk),
    .reg_wr(reg_wr), .reg_rd(reg_rd), .reg_addr(reg_addr), .reg_wdata(reg_wdata),
    .reg_rdata(reg_rdata), .irq_rxi(irq_rxi), .irq_eri(irq_eri), .irq_bri(irq_bri)
  );

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_err++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  // ---------------- reference model ----------------
  logic [9:0] m_q[$];
  logic       m_rie, m_rxen, started = 1'b0;
  logic [1:0] m_sel;
  logic [5:0] m_flags, m_arm, m_old, m_set;
  int         m_cnt, m_trig;

  function automatic int trig_of(input logic [1:0] s);
    case (s)
      2'd0: return 1;
      2'd1: return 4;
      2'd2: return 8;
      default: return 14;
    endcase
  endfunction

  always @(posedge clk) begin
    if (rst) begin
      m_q.delete();
      m_rie = 0; m_rxen = 0; m_sel = 0; m_flags = 0; m_arm = 0;
      started = 1'b1;
    end else begin
      m_cnt  = m_q.size();
      m_trig = trig_of(m_sel);
      m_old  = m_flags;
      m_set  = '0;
      if (reg_rd && reg_addr == 2'd2 && m_cnt > 0) void'(m_q.pop_front());
      if (in_valid && m_rxen) begin
        if (in_brk) m_set[2] = 1'b1;
        else if (m_cnt == 16) begin m_set[5] = 1'b1; m_set[1] = 1'b1; end
        else begin
          m_q.push_back({in_per, in_fer, in_data});
          if (in_fer) begin m_set[3] = 1'b1; m_set[1] = 1'b1; end
          if (in_per) begin m_set[4] = 1'b1; m_set[1] = 1'b1; end
        end
      end
      if (m_cnt >= m_trig) m_set[0] = 1'b1;
      for (int i = 0; i < 6; i++) begin
        if (m_set[i]) m_flags[i] = 1'b1;
        else if (reg_wr && reg_addr == 2'd1 && m_arm[i] && !reg_wdata[i] &&
                 (i != 0 || m_cnt < m_trig)) m_flags[i] = 1'b0;
      end
      if (reg_wr && reg_addr == 2'd1) m_arm = '0;
      else if (reg_rd && reg_addr == 2'd1) m_arm = m_arm | m_old;
      if (reg_wr && reg_addr == 2'd0) begin
        m_rie = reg_wdata[0]; m_rxen = reg_wdata[1]; m_sel = reg_wdata[3:2];
      end
    end
  end

  function automatic logic [7:0] exp_rdata(input logic [1:0] a);
    case (a)
      2'd0: return {4'b0, m_sel, m_rxen, m_rie};
      2'd1: return {2'b0, m_flags};
      2'd2: return (m_q.size() > 0) ? m_q[0][7:0] : 8'h00;
      default: return (m_q.size() > 0) ?
                 {1'b0, m_q[0][9], m_q[0][8], 5'(m_q.size())} : 8'h00;
    endcase
  endfunction

  // per-cycle comparison, away from the active edge
  always @(negedge clk) begin
    if (started && !rst) begin
      chk("R5 irq_rxi", irq_rxi, m_rie & m_flags[0]);
      chk("R5 irq_eri", irq_eri, m_rie & m_flags[1]);
      chk("R5 irq_bri", irq_bri, m_rie & m_flags[2]);
      chk("R6 in_ready", in_ready, m_rxen);
      chk("R2/R12/R7 reg_rdata", reg_rdata, exp_rdata(reg_addr));
    end
  end

  // ---------------- stimulus helpers ----------------
  task automatic cyc();
    @(negedge clk); #1;
  endtask

  task automatic wr_reg(input logic [1:0] a, input logic [7:0] d);
    reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
    cyc();
    reg_wr = 1'b0;
  endtask

  task automatic rd_reg(input logic [1:0] a, output logic [7:0] d);
    reg_rd = 1'b1; reg_addr = a;
    #1 d = reg_rdata;
    cyc();
    reg_rd = 1'b0;
  endtask

  task automatic push(input logic [7:0] d, input logic fe, input logic pe, input logic bk);
    in_valid = 1'b1; in_data = d; in_fer = fe; in_per = pe; in_brk = bk;
    cyc();
    in_valid = 1'b0; in_fer = 1'b0; in_per = 1'b0; in_brk = 1'b0;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_err++;
    $display("FAIL watchdog expired");
    $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
    $finish;
  end

  initial begin
    logic [7:0] v;
    repeat (3) @(posedge clk);
    cyc(); rst = 1'b0;
    cyc();
    rd_reg(2'd0, v); chk("R1 ctrl after reset", v, 8'h00);
    rd_reg(2'd1, v); chk("R1 status after reset", v, 8'h00);
    chk("R1 irq after reset", {irq_rxi, irq_eri, irq_bri}, 3'b000);

    wr_reg(2'd0, 8'hF7);
    rd_reg(2'd0, v); chk("R2 reserved bits read 0", v, 8'h07);

    push(8'hA1, 0, 0, 0); push(8'hA2, 0, 0, 0); push(8'hA3, 0, 0, 0);
    cyc(); chk("R3 below trigger 4", irq_rxi, 1'b0);
    push(8'hA4, 0, 0, 0);
    cyc(); chk("R3 threshold at 4", irq_rxi, 1'b1);

    wr_reg(2'd1, 8'h00); cyc();
    chk("R4 clear without prior read ignored", irq_rxi, 1'b1);
    rd_reg(2'd1, v); chk("R12 status threshold bit", v, 8'h01);
    wr_reg(2'd1, 8'h00); cyc();
    chk("R4 clear at level>=trigger refused", irq_rxi, 1'b1);
    rd_reg(2'd3, v); chk("R7 level word", v, 8'h04);
    rd_reg(2'd2, v); chk("R7 first popped", v, 8'hA1);
    rd_reg(2'd1, v);
    wr_reg(2'd1, 8'h00); cyc();
    rd_reg(2'd1, v); chk("R4 guarded clear succeeds", v, 8'h00);
    chk("R4 irq_rxi dropped", irq_rxi, 1'b0);

    push(8'h55, 1, 0, 0); cyc();
    rd_reg(2'd1, v); chk("R8 framing error flags", v, 8'h0B);
    chk("R8 irq_eri", irq_eri, 1'b1);
    push(8'h00, 0, 0, 1); cyc();
    rd_reg(2'd1, v); chk("R10 break flag", v, 8'h0F);
    chk("R10 irq_bri", irq_bri, 1'b1);
    rd_reg(2'd3, v); chk("R10 break not stored", v, 8'h04);

    wr_reg(2'd0, 8'h06); cyc();
    chk("R5 enable cleared drops requests", {irq_rxi, irq_eri, irq_bri}, 3'b000);
    rd_reg(2'd1, v); chk("R5 flags kept", v, 8'h0F);

    wr_reg(2'd0, 8'h04);
    push(8'h77, 0, 0, 0); cyc();
    rd_reg(2'd3, v); chk("R6 receiver off ignores input", v, 8'h04);
    rd_reg(2'd1, v); chk("R6 flags kept with receiver off", v, 8'h0F);
    wr_reg(2'd1, 8'h01); cyc();
    rd_reg(2'd1, v); chk("R11 read-1 write-0 clears", v, 8'h01);

    wr_reg(2'd0, 8'h07);
    rd_reg(2'd2, v); chk("R7 order 2", v, 8'hA2);
    rd_reg(2'd2, v); chk("R7 order 3", v, 8'hA3);
    rd_reg(2'd2, v); chk("R7 order 4", v, 8'hA4);
    rd_reg(2'd3, v); chk("R8 head framing tag", v, 8'h21);
    rd_reg(2'd2, v); chk("R8 stored data", v, 8'h55);
    rd_reg(2'd2, v); chk("R7 empty pop reads 0", v, 8'h00);
    rd_reg(2'd3, v); chk("R7 empty level", v, 8'h00);

    for (int i = 0; i < 17; i++) push(8'(8'h10 + i), 0, 0, 0);
    cyc();
    rd_reg(2'd1, v); chk("R9 overrun flags", v, 8'h23);
    rd_reg(2'd3, v); chk("R9 level held at 16", v, 8'h10);

    wr_reg(2'd0, 8'h0F);
    rd_reg(2'd2, v); chk("R9 oldest kept", v, 8'h10);
    rd_reg(2'd2, v); rd_reg(2'd2, v);
    cyc();
    rd_reg(2'd1, v);
    wr_reg(2'd1, 8'h00); cyc();
    rd_reg(2'd1, v); chk("R11 all cleared at level 13", v, 8'h00);
    push(8'hEE, 0, 0, 0); cyc();
    chk("R3 threshold at 14", irq_rxi, 1'b1);
    cyc();

    $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
    $finish;
  end

endmodule